// File: doc/BRIEF.md
# Sparse Register File

This block is a two-read, one-write register file for a 32-bit integer core whose instruction set addresses 32 general registers with 5-bit fields. Only nine of those addresses have storage: address 0, which is hardwired to zero, and the eight addresses 1, 2, 5, 6, 7, 8, 9 and 10. Every other address reads as zero, and a write to it is dropped. This keeps area small for a core whose software keeps to a reduced register set.

Both read ports are combinational. The single write port commits on a rising clock edge when its enable is high. The clock goes straight to the flops, and the enable is the only thing that qualifies a write. Eight observation buses always show the eight non-zero stored registers, so a test harness can watch architectural state without using the read ports. A synchronous active-high reset clears all stored registers.

Top module: `sparse_regfile`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge), every stored register reads 0 on both read ports and on all eight observation buses.
- R2: When wr_en is 1 at a rising edge and wr_addr is a stored non-zero address (1, 2, 5, 6, 7, 8, 9 or 10), that register takes wr_data. The new value appears on the read ports and on the observation buses after that edge.
- R3: When wr_en is 0 at a rising edge, no register changes.
- R4: A write changes only the register addressed by wr_addr. Every other register keeps its value.
- R5: Address 0 always reads 0, and a write to address 0 with wr_en high changes no register.
- R6: An address outside the stored set (3, 4 and 11 to 31) reads 0, and a write to it changes no register.
- R7: rd_data_a and rd_data_b show the register selected by rd_addr_a and rd_addr_b combinationally, in the same cycle the address is applied. The two ports are independent of each other.
- R8: A read of the register being written in the same cycle returns the old value. The new value is visible only after the edge.
- R9: The observation buses show the registers at addresses 1, 2, 5, 6, 7, 8, 9 and 10 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, wired directly to the storage flops |
| rst | input | 1 | Synchronous active-high clear |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr_a | input | 5 | Read address, port A |
| rd_addr_b | input | 5 | Read address, port B |
| rd_data_a | output | 32 | Read data, port A |
| rd_data_b | output | 32 | Read data, port B |
| obs_r1 | output | 32 | Contents of register 1 |
| obs_r2 | output | 32 | Contents of register 2 |
| obs_r5 | output | 32 | Contents of register 5 |
| obs_r6 | output | 32 | Contents of register 6 |
| obs_r7 | output | 32 | Contents of register 7 |
| obs_r8 | output | 32 | Contents of register 8 |
| obs_r9 | output | 32 | Contents of register 9 |
| obs_r10 | output | 32 | Contents of register 10 |

## Verification
The assertions assume that wr_en and all addresses are 0 or 1 at each sampled clock edge, never X or Z. They also assume that reset is asserted during the first clock edge. The bench holds reset from time zero and drives every input from tasks on the falling edge, so every value is settled and known at each rising edge. Each write address from 0 to 31 is swept with wr_en both high and low. Distinct data patterns show which register was touched, and both read ports are swept over all 32 addresses after each step.

// File: rtl/sparse_regfile_pkg.sv
package sparse_regfile_pkg;
  localparam int XLEN      = 32;
  localparam int AW        = 5;
  localparam int NUM_ADDR  = 1 << AW;
  localparam int NUM_SLOTS = 8;

  typedef logic [XLEN-1:0] word_t;
  typedef logic [AW-1:0]   addr_t;

  // slot index -> architectural address
  function automatic addr_t slot_addr(input int unsigned s);
    case (s)
      0: slot_addr = addr_t'(1);
      1: slot_addr = addr_t'(2);
      default: slot_addr = addr_t'(s + 3);
    endcase
  endfunction

  // address is backed by a stored non-zero register
  function automatic logic is_stored(input addr_t a);
    is_stored = (a == addr_t'(1)) || (a == addr_t'(2)) ||
                (a >= addr_t'(5) && a <= addr_t'(10));
  endfunction
endpackage

// File: rtl/sparse_regfile_decode.sv
module sparse_regfile_decode
  import sparse_regfile_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS
) (
  input  logic             wr_en,
  input  addr_t            wr_addr,
  output logic [SLOTS-1:0] slot_we
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_dec
    assign slot_we[s] = wr_en && (wr_addr == slot_addr(s));
  end

  always_comb begin
    assert (!(|slot_we) || is_stored(wr_addr)) else $error("p_dec_stored_r6");
    assert ($onehot0(slot_we)) else $error("p_dec_onehot_r4");
  end
endmodule

// File: rtl/sparse_regfile_slot.sv
module sparse_regfile_slot
  import sparse_regfile_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  word_t din,
  output word_t q
);
  word_t q_r;
  always_ff @(posedge clk) begin
    if (rst)     q_r <= '0;
    else if (we) q_r <= din;
  end
  assign q = q_r;

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(din)));
endmodule

// File: rtl/sparse_regfile_rdmux.sv
module sparse_regfile_rdmux
  import sparse_regfile_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS
) (
  input  word_t             slots [SLOTS],
  input  addr_t             addr,
  output word_t             dout
);
  logic [SLOTS-1:0] hit;
  for (genvar s = 0; s < SLOTS; s++) begin : g_hit
    assign hit[s] = (addr == slot_addr(s));
  end

  always_comb begin
    dout = '0;
    for (int s = 0; s < SLOTS; s++)
      if (hit[s]) dout = dout | slots[s];
  end

  always_comb begin
    assert ($onehot0(hit)) else $error("p_rd_onehot_r7");
    assert (is_stored(addr) || dout == '0) else $error("p_rd_zero_r6");
  end
endmodule

// File: rtl/sparse_regfile.sv
module sparse_regfile
  import sparse_regfile_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_addr_a,
  input  logic [4:0]  rd_addr_b,
  output logic [31:0] rd_data_a,
  output logic [31:0] rd_data_b,
  output logic [31:0] obs_r1,
  output logic [31:0] obs_r2,
  output logic [31:0] obs_r5,
  output logic [31:0] obs_r6,
  output logic [31:0] obs_r7,
  output logic [31:0] obs_r8,
  output logic [31:0] obs_r9,
  output logic [31:0] obs_r10
);
  logic [NUM_SLOTS-1:0] slot_we;
  word_t                slot_q [NUM_SLOTS];

  sparse_regfile_decode #(.SLOTS(NUM_SLOTS)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .slot_we(slot_we));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    sparse_regfile_slot u_slot (
      .clk(clk), .rst(rst), .we(slot_we[s]), .din(wr_data), .q(slot_q[s]));
  end

  sparse_regfile_rdmux #(.SLOTS(NUM_SLOTS)) u_rda (
    .slots(slot_q), .addr(rd_addr_a), .dout(rd_data_a));
  sparse_regfile_rdmux #(.SLOTS(NUM_SLOTS)) u_rdb (
    .slots(slot_q), .addr(rd_addr_b), .dout(rd_data_b));

  assign obs_r1  = slot_q[0];
  assign obs_r2  = slot_q[1];
  assign obs_r5  = slot_q[2];
  assign obs_r6  = slot_q[3];
  assign obs_r7  = slot_q[4];
  assign obs_r8  = slot_q[5];
  assign obs_r9  = slot_q[6];
  assign obs_r10 = slot_q[7];

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (obs_r1 == '0 && obs_r10 == '0 && obs_r5 == '0));
  p_x0_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0) |-> (rd_data_a == '0));
  p_x0_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_addr == '0) |=> ($stable(obs_r1) && $stable(obs_r2) && $stable(obs_r10)));
  p_bad_write_r6: assert property (@(posedge clk) disable iff (rst)
    !is_stored(wr_addr) |=> ($stable(obs_r5) && $stable(obs_r9)));
  p_obs_read_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == 5'd7) |-> (rd_data_b == obs_r7));
endmodule

// File: tb/sparse_regfile_tb.sv
module sparse_regfile_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr_a = '0, rd_addr_b = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data_a, rd_data_b;
  logic [31:0] obs [8];

  int checks = 0, errors = 0;
  logic [31:0] model [32];

  always #5 clk = ~clk;

  sparse_regfile u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .obs_r1(obs[0]), .obs_r2(obs[1]), .obs_r5(obs[2]), .obs_r6(obs[3]),
    .obs_r7(obs[4]), .obs_r8(obs[5]), .obs_r9(obs[6]), .obs_r10(obs[7]));

  function automatic bit stored(int a);
    return a == 1 || a == 2 || (a >= 5 && a <= 10);
  endfunction
  function automatic int obs_addr(int i);
    return i < 2 ? i + 1 : i + 3;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sweep both read ports and the observation buses against the model
  task automatic sweep(string req);
    for (int a = 0; a < 32; a++) begin
      rd_addr_a = 5'(a); rd_addr_b = 5'(31 - a);
      #1;
      chk(req, rd_data_a, model[a]);
      chk(req, rd_data_b, model[31 - a]);
    end
    for (int i = 0; i < 8; i++) chk({req, "/R9"}, obs[i], model[obs_addr(i)]);
  endtask

  task automatic do_write(bit en, int a, logic [31:0] d);
    @(negedge clk);
    wr_en = en; wr_addr = 5'(a); wr_data = d;
    @(posedge clk);
    if (en && stored(a)) model[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 32; a++) model[a] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    sweep("R1");
    // R2, R4, R5, R6: write every address, sweep everything after
    for (int a = 0; a < 32; a++) begin
      do_write(1'b1, a, 32'hA5000000 | (a * 32'h00010101) | 32'h80);
      sweep("R2/R4/R5/R6");
    end
    // R3: disabled writes to every address
    for (int a = 0; a < 32; a++) do_write(1'b0, a, 32'hDEAD0000 | 32'(a));
    sweep("R3");
    // R7: independent ports, same address on both
    rd_addr_a = 5'd9; rd_addr_b = 5'd9; #1;
    chk("R7", rd_data_a, model[9]); chk("R7", rd_data_b, model[9]);
    // R8: same-cycle read of the register being written
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd6; wr_data = 32'h12345678;
    rd_addr_a = 5'd6; rd_addr_b = 5'd6; #1;
    chk("R8", rd_data_a, model[6]);
    @(posedge clk); model[6] = 32'h12345678; #1;
    chk("R8", rd_data_b, 32'h12345678);
    @(negedge clk); wr_en = 1'b0;
    // R5: write x0 with all ones
    do_write(1'b1, 0, 32'hFFFFFFFF);
    sweep("R5");
    // R1: reset again clears
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    for (int a = 0; a < 32; a++) model[a] = '0;
    @(negedge clk); rst = 1'b0;
    sweep("R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule